// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block shapes the strobe timing of every access that an internal master makes to one external memory area. A request arrives on a single-cycle port, together with its direction, its byte lanes, a burst length and the upper address bits. The block checks whether those address bits select its area. If they do, it runs the access through four phases: address setup, the active strobe, optional burst beats, and hold. It reports the end of the access with a one-cycle acknowledge.

Timing comes from two independent groups of configuration fields. The base group sets a setup of zero or one cycle, a coded wait count from 0 to 15 and a hold of 0 to 3 cycles. The card group applies only in card mode. There it adds an extra setup and an extra hold, each of up to 15 cycles, and up to 50 further wait cycles on top of the base waits.

An active-low external wait pin passes through a two-flop synchronizer. Once the programmed count has run out, the pin holds the strobe for as long as it stays asserted. In SRAM mode the block drives a chip select, a read strobe and per-lane write strobes. In card mode it drives two card enables, a register-space select and separate I/O read and I/O write strobes.

Top module: `xbus_seq`

## Requirements
- R1: A request is taken only when req_addr_hi[4:2] (address bits 28..26) equal 3'b110. A request with any other value drives no output low and produces no ack.
- R2: The base wait code maps 000→0, 001→1, 010→2, 011→3, 100→4, 101→6, 110→9 and 111→15 waits. With the wait pin idle, the strobe stays low for waits+1 cycles.
- R3: When cfg_setup_code is 1, the select is low for one cycle before the strobe falls. When it is 0, the strobe falls in cycle 1, the first cycle after the accepting edge.
- R4: After the strobe rises, the select stays low for cfg_hold_code (0 to 3) further cycles.
- R5: In card mode, the card setup and card hold codes each map 00→0, 01→1, 10→2 and 11→15 cycles. Each value is added to the matching base setup or base hold.
- R6: In card mode, the card wait code maps 00→0, 01→15, 10→30 and 11→50 waits. This value is added to the base waits.
- R7: ext_wait_n is active low and passes through two synchronizer flops. It is examined only after the programmed waits are used up, and the strobe is held while the synchronized pin is asserted. If the pin rises during strobe cycle c, and that cycle is at or after the last programmed cycle, the strobe ends after cycle c+2. A pin release that is seen before the count runs out does not lengthen the strobe.
- R8: A read with req_len = n runs n further beats after the first. Each later beat keeps the strobe low for 2 + cfg_wait_code cycles. beat pulses in the last cycle of every beat. A write ignores req_len and runs one beat.
- R9: In SRAM mode, cs_n is low through every phase of the access. rd_n is low during the strobe of a read. we_n[i] is low during the strobe of a write whose req_be[i] is 1. The card outputs stay high.
- R10: In card mode, cs_n stays high. ce1_n is low through the whole access when req_be[0] is 1 or req_be[1] is 0, and ce2_n is low through the whole access when req_be[1] is 1. reg_n is low through the access when address bit 25 (req_addr_hi[1], I/O space) or bit 24 (req_addr_hi[0], attribute space) is set. In I/O space the strobe is iord_n or iowr_n. Otherwise the strobe is rd_n, or we_n[0] alone for a write.
- R11: ack is high for exactly one cycle, the last cycle of the access (the last hold cycle, or the last strobe cycle when the total hold is zero). A request presented while an access is running is ignored.
- R12: While rst is high, all strobe and select outputs are high, and ack and beat are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr_hi | input | 5 | Address bits 28..24 |
| req_be | input | BE_W | Byte lane enables |
| req_len | input | LEN_W | Extra burst beats (reads only) |
| cfg_card_mode | input | 1 | 0 = SRAM mode, 1 = card mode |
| cfg_wait_code | input | 3 | Base wait code |
| cfg_setup_code | input | 1 | Base setup, 0 or 1 cycle |
| cfg_hold_code | input | 2 | Base hold, 0 to 3 cycles |
| cfg_card_setup | input | 2 | Card extra setup code |
| cfg_card_hold | input | 2 | Card extra hold code |
| cfg_card_wait | input | 2 | Card extra wait code |
| ext_wait_n | input | 1 | External wait pin, active low |
| ack | output | 1 | Access complete pulse |
| beat | output | 1 | End-of-beat pulse |
| cs_n | output | 1 | SRAM chip select |
| rd_n | output | 1 | Read strobe / output enable |
| we_n | output | BE_W | Per-lane write strobes |
| ce1_n | output | 1 | Card enable, low lane |
| ce2_n | output | 1 | Card enable, high lane |
| iord_n | output | 1 | Card I/O read strobe |
| iowr_n | output | 1 | Card I/O write strobe |
| reg_n | output | 1 | Card register-space select |

## Verification
The bench builds the block with BE_W = 8, LEN_W = 3 and two synchronizer stages. Eight write lanes make distinct lane masks visible on we_n. A three-bit length allows a four-beat read burst. Combining the largest card codes with the base codes reaches the extreme totals: 65 waits, 16 setup cycles and 18 hold cycles. The two-stage synchronizer gives a fixed two-cycle distance between a pin release and the end of the strobe, and the bench checks that distance cycle for cycle.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int CNT_W    = 7;   // holds up to 65 waits, 18 hold, 16 setup
    localparam int HI_W     = 5;   // address bits 28..24
    localparam logic [2:0] AREA_CODE = 3'b110;
    localparam int IO_POS   = 1;   // bit 25 inside req_addr_hi
    localparam int ATTR_POS = 0;   // bit 24 inside req_addr_hi

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_BURST,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] waits;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] beat_len;
    } timing_t;

    function automatic logic [CNT_W-1:0] base_waits(input logic [2:0] code);
        case (code)
            3'd0:    return CNT_W'(0);
            3'd1:    return CNT_W'(1);
            3'd2:    return CNT_W'(2);
            3'd3:    return CNT_W'(3);
            3'd4:    return CNT_W'(4);
            3'd5:    return CNT_W'(6);
            3'd6:    return CNT_W'(9);
            default: return CNT_W'(15);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] card_edge(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(0);
            2'd1:    return CNT_W'(1);
            2'd2:    return CNT_W'(2);
            default: return CNT_W'(15);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] card_waits(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(0);
            2'd1:    return CNT_W'(15);
            2'd2:    return CNT_W'(30);
            default: return CNT_W'(50);
        endcase
    endfunction

endpackage

// File: rtl/xbs_timing.sv
module xbs_timing
    import xbs_pkg::*;
(
    input  logic       card_mode,
    input  logic [2:0] wait_code,
    input  logic       setup_code,
    input  logic [1:0] hold_code,
    input  logic [1:0] card_setup,
    input  logic [1:0] card_hold,
    input  logic [1:0] card_wait,
    output timing_t    tm
);
    logic [CNT_W-1:0] ex_setup, ex_hold, ex_wait;

    always_comb begin
        ex_setup = card_mode ? card_edge(card_setup) : '0;
        ex_hold  = card_mode ? card_edge(card_hold)  : '0;
        ex_wait  = card_mode ? card_waits(card_wait) : '0;
        tm.setup    = CNT_W'(setup_code) + ex_setup;
        tm.waits    = base_waits(wait_code) + ex_wait;
        tm.hold     = CNT_W'(hold_code) + ex_hold;
        tm.beat_len = CNT_W'(wait_code) + CNT_W'(2);
    end
endmodule

// File: rtl/xbs_wait_sync.sv
module xbs_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic wait_s
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], ~pin_n};
    end

    assign wait_s = sr[STAGES-1];
endmodule

// File: rtl/xbs_sequencer.sv
module xbs_sequencer
    import xbs_pkg::*;
#(
    parameter int BE_W  = 8,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             req_write,
    input  logic             req_io,
    input  logic             req_attr,
    input  logic [BE_W-1:0]  req_be,
    input  logic [LEN_W-1:0] req_len,
    input  logic             card_mode,
    input  timing_t          tm,
    input  logic             wait_s,
    output phase_e           phase,
    output logic [BE_W-1:0]  be_q,
    output logic             write_q,
    output logic             io_q,
    output logic             attr_q,
    output logic             card_q,
    output logic             ack,
    output logic             beat
);
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] left;
    timing_t          tm_q;

    assign beat = ((phase == PH_STROBE) && (cnt == '0) && !wait_s) ||
                  ((phase == PH_BURST)  && (cnt == '0));
    assign ack  = ((phase == PH_HOLD) && (cnt == '0)) ||
                  (beat && (left == '0) && (tm_q.hold == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            left    <= '0;
            tm_q    <= '0;
            be_q    <= '0;
            write_q <= 1'b0;
            io_q    <= 1'b0;
            attr_q  <= 1'b0;
            card_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        tm_q    <= tm;
                        be_q    <= req_be;
                        write_q <= req_write;
                        io_q    <= req_io;
                        attr_q  <= req_attr;
                        card_q  <= card_mode;
                        left    <= req_write ? '0 : req_len;
                        if (tm.setup != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= tm.setup - 1'b1;
                        end else begin
                            phase <= PH_STROBE;
                            cnt   <= tm.waits;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= tm_q.waits;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE, PH_BURST: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (beat) begin
                        if (left != '0) begin
                            phase <= PH_BURST;
                            cnt   <= tm_q.beat_len - 1'b1;
                            left  <= left - 1'b1;
                        end else if (tm_q.hold != '0) begin
                            phase <= PH_HOLD;
                            cnt   <= tm_q.hold - 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_ack_single_R11: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    assert_ack_to_idle_R11: assert property (@(posedge clk) disable iff (rst)
        ack |=> (phase == PH_IDLE));
    assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && cnt == '0 && wait_s) |=> (phase == PH_STROBE));
    assert_hold_countdown_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && cnt != '0) |=> (phase == PH_HOLD && cnt == $past(cnt) - 1'b1));
    assert_burst_read_only_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BURST) |-> !write_q);
endmodule

// File: rtl/xbs_pins.sv
module xbs_pins
    import xbs_pkg::*;
#(
    parameter int BE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_e          phase,
    input  logic [BE_W-1:0] be_q,
    input  logic            write_q,
    input  logic            io_q,
    input  logic            attr_q,
    input  logic            card_q,
    output logic            cs_n,
    output logic            rd_n,
    output logic [BE_W-1:0] we_n,
    output logic            ce1_n,
    output logic            ce2_n,
    output logic            iord_n,
    output logic            iowr_n,
    output logic            reg_n
);
    logic busy, strobe, io_path;

    assign busy    = (phase != PH_IDLE);
    assign strobe  = (phase == PH_STROBE) || (phase == PH_BURST);
    assign io_path = card_q && io_q;

    assign cs_n   = !(busy && !card_q);
    assign rd_n   = !(strobe && !write_q && !io_path);
    assign ce1_n  = !(busy && card_q && (be_q[0] || !be_q[1]));
    assign ce2_n  = !(busy && card_q && be_q[1]);
    assign iord_n = !(strobe && io_path && !write_q);
    assign iowr_n = !(strobe && io_path && write_q);
    assign reg_n  = !(busy && card_q && (io_q || attr_q));

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign we_n[i] = !(strobe && write_q && (card_q ? !io_q : be_q[i]));
        end else begin : g_rest
            assign we_n[i] = !(strobe && write_q && !card_q && be_q[i]);
        end
    end

    assert_single_dir_R9: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && (we_n != '1)));
    assert_strobe_selected_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || (we_n != '1) || !iord_n || !iowr_n) |-> (!cs_n || !ce1_n || !ce2_n));
    assert_sram_quiet_card_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (ce1_n && ce2_n && reg_n && iord_n && iowr_n));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbs_pkg::*;
#(
    parameter int BE_W        = 8,
    parameter int LEN_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [HI_W-1:0]  req_addr_hi,
    input  logic [BE_W-1:0]  req_be,
    input  logic [LEN_W-1:0] req_len,
    input  logic             cfg_card_mode,
    input  logic [2:0]       cfg_wait_code,
    input  logic             cfg_setup_code,
    input  logic [1:0]       cfg_hold_code,
    input  logic [1:0]       cfg_card_setup,
    input  logic [1:0]       cfg_card_hold,
    input  logic [1:0]       cfg_card_wait,
    input  logic             ext_wait_n,
    output logic             ack,
    output logic             beat,
    output logic             cs_n,
    output logic             rd_n,
    output logic [BE_W-1:0]  we_n,
    output logic             ce1_n,
    output logic             ce2_n,
    output logic             iord_n,
    output logic             iowr_n,
    output logic             reg_n
);
    timing_t         tm;
    phase_e          phase;
    logic            wait_s, hit, go;
    logic [BE_W-1:0] be_q;
    logic            write_q, io_q, attr_q, card_q;

    assign hit = (req_addr_hi[HI_W-1 -: 3] == AREA_CODE);
    assign go  = req_valid && hit;

    xbs_timing u_timing (
        .card_mode  (cfg_card_mode),
        .wait_code  (cfg_wait_code),
        .setup_code (cfg_setup_code),
        .hold_code  (cfg_hold_code),
        .card_setup (cfg_card_setup),
        .card_hold  (cfg_card_hold),
        .card_wait  (cfg_card_wait),
        .tm         (tm)
    );

    xbs_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (ext_wait_n),
        .wait_s (wait_s)
    );

    xbs_sequencer #(.BE_W(BE_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .req_write (req_write),
        .req_io    (req_addr_hi[IO_POS]),
        .req_attr  (req_addr_hi[ATTR_POS]),
        .req_be    (req_be),
        .req_len   (req_len),
        .card_mode (cfg_card_mode),
        .tm        (tm),
        .wait_s    (wait_s),
        .phase     (phase),
        .be_q      (be_q),
        .write_q   (write_q),
        .io_q      (io_q),
        .attr_q    (attr_q),
        .card_q    (card_q),
        .ack       (ack),
        .beat      (beat)
    );

    xbs_pins #(.BE_W(BE_W)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .be_q    (be_q),
        .write_q (write_q),
        .io_q    (io_q),
        .attr_q  (attr_q),
        .card_q  (card_q),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .we_n    (we_n),
        .ce1_n   (ce1_n),
        .ce2_n   (ce2_n),
        .iord_n  (iord_n),
        .iowr_n  (iowr_n),
        .reg_n   (reg_n)
    );

    assert_accept_in_area_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(phase != PH_IDLE) |-> $past(req_valid && hit));
endmodule

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_addr_hi = '0;
    logic [7:0] req_be = '0;
    logic [2:0] req_len = '0;
    logic       cfg_card_mode = 1'b0, cfg_setup_code = 1'b0;
    logic [2:0] cfg_wait_code = '0;
    logic [1:0] cfg_hold_code = '0, cfg_card_setup = '0, cfg_card_hold = '0, cfg_card_wait = '0;
    logic       ext_wait_n = 1'b1;
    logic       ack, beat, cs_n, rd_n, ce1_n, ce2_n, iord_n, iowr_n, reg_n;
    logic [7:0] we_n;

    always #2.5 clk = ~clk;

    xbus_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr_hi(req_addr_hi), .req_be(req_be), .req_len(req_len),
        .cfg_card_mode(cfg_card_mode), .cfg_wait_code(cfg_wait_code),
        .cfg_setup_code(cfg_setup_code), .cfg_hold_code(cfg_hold_code),
        .cfg_card_setup(cfg_card_setup), .cfg_card_hold(cfg_card_hold),
        .cfg_card_wait(cfg_card_wait), .ext_wait_n(ext_wait_n),
        .ack(ack), .beat(beat), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .iord_n(iord_n), .iowr_n(iowr_n), .reg_n(reg_n)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_base(input logic [2:0] c);
        case (c)
            3'd5: return 6;
            3'd6: return 9;
            3'd7: return 15;
            default: return int'(c);
        endcase
    endfunction
    function automatic int m_edge(input logic [1:0] c);
        return (c == 2'd3) ? 15 : int'(c);
    endfunction
    function automatic int m_cwait(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 15;
            2'd2: return 30;
            default: return 50;
        endcase
    endfunction

    // card, wait, setup, hold, csetup, chold, cwait, write, io, attr, be
    localparam int NV = 9;
    localparam logic [23:0] VECS [0:NV-1] = '{
        {1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
        {1'b0, 3'd1, 1'b1, 2'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h0F},
        {1'b0, 3'd5, 1'b0, 2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
        {1'b0, 3'd6, 1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h81},
        {1'b0, 3'd7, 1'b1, 2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h3C},
        {1'b1, 3'd3, 1'b1, 2'd1, 2'd1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 8'h01},
        {1'b1, 3'd4, 1'b0, 2'd0, 2'd3, 2'd3, 2'd2, 1'b1, 1'b1, 1'b0, 8'h03},
        {1'b1, 3'd2, 1'b1, 2'd2, 2'd2, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 8'h02},
        {1'b1, 3'd0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 8'h01}
    };

    int pre, st, post, beats;
    bit acked, idle_after;
    logic [14:0] sig;

    function automatic bit quiet();
        return cs_n && rd_n && (we_n == 8'hFF) && ce1_n && ce2_n && iord_n && iowr_n && reg_n;
    endfunction

    task automatic run_access(input logic wr, input logic io, input logic at,
                              input logic [7:0] be, input logic [2:0] len, input int rel);
        bit seen = 0;
        int guard = 0;
        pre = 0; st = 0; post = 0; beats = 0; sig = '0; acked = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr_hi = {3'b110, io, at};
        req_be = be; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        while (!acked && guard < 3000) begin
            if (!rd_n || (we_n != 8'hFF) || !iord_n || !iowr_n) begin
                st++; seen = 1;
                if (rel > 0 && st == rel) ext_wait_n = 1'b1;
            end else if (!cs_n || !ce1_n || !ce2_n) begin
                if (seen) post++; else pre++;
            end
            if (beat) beats++;
            sig |= {!cs_n, !ce1_n, !ce2_n, !reg_n, !rd_n, !iord_n, !iowr_n, ~we_n};
            if (ack) acked = 1;
            else @(negedge clk);
            guard++;
        end
        @(negedge clk);
        idle_after = !ack && quiet();
    endtask

    task automatic set_cfg(input logic c, input logic [2:0] w, input logic s, input logic [1:0] h,
                           input logic [1:0] cs_, input logic [1:0] ch, input logic [1:0] cw);
        cfg_card_mode = c; cfg_wait_code = w; cfg_setup_code = s; cfg_hold_code = h;
        cfg_card_setup = cs_; cfg_card_hold = ch; cfg_card_wait = cw;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt_ack, cnt_we, cnt_act;
        // R12: reset state
        repeat (4) @(negedge clk);
        check(quiet() && !ack && !beat, "R12 reset outputs", int'(quiet()), 1);
        rst = 1'b0;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            logic c, s, wr, io, at;
            logic [2:0] w;
            logic [1:0] h, csu, chd, cwt;
            logic [7:0] be;
            int es, ew, eh;
            logic [14:0] esig;
            logic [7:0] ewe;
            v = VECS[i];
            {c, w, s, h, csu, chd, cwt, wr, io, at, be} = v;
            set_cfg(c, w, s, h, csu, chd, cwt);
            es = int'(s) + (c ? m_edge(csu) : 0);
            ew = m_base(w) + (c ? m_cwait(cwt) : 0);
            eh = int'(h) + (c ? m_edge(chd) : 0);
            run_access(wr, io, at, be, 3'd0, 0);
            check(pre == es, c ? "R5 setup (card)" : "R3 setup", pre, es);
            check(st == ew + 1, c ? "R6 strobe waits (card)" : "R2 strobe waits", st, ew + 1);
            check(post == eh, c ? "R5 hold (card)" : "R4 hold", post, eh);
            check(acked && idle_after, "R11 ack in last cycle then idle", int'(acked && idle_after), 1);
            ewe = wr ? (c ? (io ? 8'h00 : 8'h01) : be) : 8'h00;
            esig = {!c, c && (be[0] || !be[1]), c && be[1], c && (io || at),
                    !wr && !(c && io), c && io && !wr, c && io && wr, ewe};
            check(sig == esig, c ? "R10 card pins" : "R9 sram pins", int'(sig), int'(esig));
        end

        // R8: four-beat read burst, wait code 2 -> first beat 3, later beats 4
        set_cfg(1'b0, 3'd2, 1'b0, 2'd1, 2'd0, 2'd0, 2'd0);
        run_access(1'b0, 1'b0, 1'b0, 8'hFF, 3'd3, 0);
        check(st == 3 + 3 * 4, "R8 burst strobe length", st, 15);
        check(beats == 4, "R8 burst beat pulses", beats, 4);
        check(post == 1 && acked, "R8 burst hold and ack", post, 1);
        // R8: write ignores length
        run_access(1'b1, 1'b0, 1'b0, 8'hFF, 3'd3, 0);
        check(st == 3 && beats == 1, "R8 write single beat", st, 3);

        // R7: pin held, zero programmed waits, release in strobe cycle 10
        set_cfg(1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        ext_wait_n = 1'b0;
        repeat (4) @(negedge clk);
        run_access(1'b0, 1'b0, 1'b0, 8'hFF, 3'd0, 10);
        check(st == 12, "R7 wait pin stretch", st, 12);
        // R7: release seen before the count expires has no effect
        set_cfg(1'b0, 3'd7, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        ext_wait_n = 1'b0;
        repeat (4) @(negedge clk);
        run_access(1'b0, 1'b0, 1'b0, 8'hFF, 3'd0, 3);
        check(st == 16, "R7 early release no stretch", st, 16);

        // R1: outside the area
        set_cfg(1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        for (int k = 0; k < 2; k++) begin
            cnt_act = 0; cnt_ack = 0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_be = 8'hFF;
            req_addr_hi = (k == 0) ? 5'b10100 : 5'b11100;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (20) begin
                if (!quiet()) cnt_act++;
                if (ack) cnt_ack++;
                @(negedge clk);
            end
            check(cnt_act == 0 && cnt_ack == 0, "R1 other area ignored", cnt_act + cnt_ack, 0);
        end

        // R11: request while busy is ignored
        set_cfg(1'b0, 3'd7, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        cnt_ack = 0; cnt_we = 0; cnt_act = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr_hi = 5'b11000; req_be = 8'hFF; req_len = 0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40) begin
            if (ack) cnt_ack++;
            if (we_n != 8'hFF) cnt_we++;
            if (cnt_ack > 0 && !ack && !quiet()) cnt_act++;
            @(negedge clk);
        end
        check(cnt_ack == 1, "R11 single ack for busy overlap", cnt_ack, 1);
        check(cnt_we == 0 && cnt_act == 0, "R11 busy request ignored", cnt_we + cnt_act, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule